// File: doc/BRIEF.md
# Power Mode Transition Controller

This block holds the operating mode of the device and moves it between a default start-up mode (DRUN), four run modes (RUN0 to RUN3) and two low-power modes (HALT and STOP). Software asks for a new mode by writing a 4-bit target code into a control register. The controller checks the request against the current mode and against a pending-interrupt flag. It then accepts the request, drops it silently, or rejects it and raises a sticky invalid-mode interrupt. From the low-power modes, hardware events bring the device back to the run mode that was active before entry.

Each run mode and HALT has its own configuration register. The register sets the flash power state, the clock-source enables and a power-domain enable mask. The controller drives these settings as outputs for the mode that is active at the time. DRUN and STOP use fixed settings. Power domains 0 and 1 are never switched off. A single write port reaches the control, status and configuration registers. All outputs come straight from registered state.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is DRUN (code 4'b0011), busy and the invalid flag are 0, every domain and clock enable is 1, flash power is normal (2'b00), and the core clock is enabled.
- R2: A control write (address 0, code in bits [3:0]) of 4'b0100..4'b0111 (RUN0..RUN3) or 4'b0011 (DRUN), made while in DRUN or a run mode, is accepted. Busy is high in the cycle after the write, and the new mode appears in the cycle after that.
- R3: A control write of 4'b1000 (HALT) or 4'b1010 (STOP) is accepted only from RUN0..RUN3. From any other mode it is rejected as invalid. In HALT and STOP the core clock enable is 0.
- R4: A HALT or STOP request from a run mode that arrives while irq_pend is high is dropped. The mode, busy and the invalid flag all stay unchanged.
- R5: HALT is left only when irq_pend is high. STOP is left when irq_pend or wake_evt is high. Either exit returns, two cycles later, to the run mode that was active before entry. wake_evt alone does not end HALT.
- R6: Domain enables 0 and 1 are 1 in every mode, whatever the mask bits say.
- R7: In RUNk (configuration address 2+k) and in HALT (address 6), the outputs follow the active mode's register. Flash power comes from bits [1:0] (00 normal, 01 low-power, 10 or 11 power-down). Clock enables come from bits [NCLK+1:2]. The domain mask comes from bits [NCLK+NDOM+1:NCLK+2], with bit i driving domain i.
- R8: A control write with an undefined code, or with a code not allowed from the current mode, leaves the mode unchanged and sets the sticky invalid flag. A status write (address 1) with bit 0 set clears the flag.
- R9: A control write made while busy is high is ignored. It changes neither the mode nor the flag.
- R10: In DRUN every domain and clock is on and flash is normal. In STOP only domains 0 and 1 are on, all clocks are off and flash is powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 status, 2..5 RUN0..3 config, 6 HALT config |
| wr_data | input | NCLK+NDOM+2 | Write data |
| irq_pend | input | 1 | Interrupt request pending |
| wake_evt | input | 1 | Wakeup event |
| cur_mode | output | 4 | Current mode code |
| busy | output | 1 | Transition in progress |
| inv_irq | output | 1 | Sticky invalid-mode interrupt |
| dom_en | output | NDOM | Power-domain enables |
| flash_pwr | output | 2 | Flash power state |
| clk_en | output | NCLK | Clock-source enables |
| core_clk_en | output | 1 | Core clock enable |

## Verification
The hardest cases to reach are the ones that depend on the history of modes rather than on a single write. These include the return to the saved run mode after HALT or STOP, a wakeup event that arrives in HALT where it must have no effect, and a second control write that lands exactly in the one busy cycle. The stimulus builds these up in order. It enters a run mode, programs distinct configurations, and then enters the low-power modes from a run mode other than RUN0, so that a wrong saved mode would show at the outputs. Busy-cycle writes are driven on back-to-back cycles. A behavioural model tracks the same history and compares every output on every cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [3:0] {
    MD_DRUN = 4'b0011,
    MD_RUN0 = 4'b0100,
    MD_RUN1 = 4'b0101,
    MD_RUN2 = 4'b0110,
    MD_RUN3 = 4'b0111,
    MD_HALT = 4'b1000,
    MD_STOP = 4'b1010
  } mode_e;

  localparam logic [1:0] FL_NORM = 2'b00;
  localparam logic [1:0] FL_LOW  = 2'b01;
  localparam logic [1:0] FL_OFF  = 2'b10;

  localparam int          CFG_SLOTS = 5;
  localparam int          ADDR_W    = 3;
  localparam logic [2:0]  A_CTRL    = 3'd0;
  localparam logic [2:0]  A_STAT    = 3'd1;
  localparam int          A_CFG0    = 2;
  localparam int          HALT_SLOT = 4;

  function automatic logic is_run(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic is_low(input logic [3:0] m);
    return (m == MD_HALT) || (m == MD_STOP);
  endfunction

  function automatic logic code_known(input logic [3:0] c);
    return is_run(c) || is_low(c) || (c == MD_DRUN);
  endfunction

endpackage

// File: rtl/pmc_cfg_bank.sv
module pmc_cfg_bank
  import pmc_pkg::*;
#(
  parameter int NDOM = 8,
  parameter int NCLK = 4,
  localparam int CFG_W = 2 + NCLK + NDOM
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [CFG_W-1:0]                    wr_data,
  output logic [CFG_SLOTS-1:0][CFG_W-1:0]     cfg_q
);

  localparam logic [CFG_W-1:0] CFG_RST = {{NDOM{1'b1}}, {NCLK{1'b1}}, FL_NORM};

  for (genvar k = 0; k < CFG_SLOTS; k++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(A_CFG0 + k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[k] <= CFG_RST;
      end else if (hit) begin
        cfg_q[k] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       clr_wr,
  input  logic [3:0] wr_target,
  input  logic       irq_pend,
  input  logic       wake_evt,
  output mode_e      mode_q,
  output logic       busy_q,
  output logic       inv_q
);

  mode_e mode_d, pend_q, pend_d, saved_q, saved_d;
  logic  busy_d, inv_d;
  logic  req_ok, req_bad, hw_exit, tgt_low;

  // request classification
  always_comb begin
    req_ok  = 1'b0;
    req_bad = 1'b0;
    tgt_low = is_low(wr_target);
    if (ctl_wr && !busy_q) begin
      if (!code_known(wr_target)) begin
        req_bad = 1'b1;
      end else if (tgt_low) begin
        if (!is_run(mode_q))  req_bad = 1'b1;
        else if (!irq_pend)   req_ok  = 1'b1;
      end else begin
        if (is_run(mode_q) || (mode_q == MD_DRUN)) req_ok  = 1'b1;
        else                                       req_bad = 1'b1;
      end
    end
  end

  assign hw_exit = !busy_q &&
                   (((mode_q == MD_HALT) && irq_pend) ||
                    ((mode_q == MD_STOP) && (irq_pend || wake_evt)));

  // next state
  always_comb begin
    mode_d  = mode_q;
    pend_d  = pend_q;
    saved_d = saved_q;
    busy_d  = 1'b0;
    if (busy_q) begin
      mode_d = pend_q;
    end else if (hw_exit) begin
      busy_d = 1'b1;
      pend_d = saved_q;
    end else if (req_ok) begin
      busy_d = 1'b1;
      pend_d = mode_e'(wr_target);
      if (tgt_low) saved_d = mode_q;
    end
    if (req_bad)     inv_d = 1'b1;
    else if (clr_wr) inv_d = 1'b0;
    else             inv_d = inv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_DRUN;
      pend_q  <= MD_DRUN;
      saved_q <= MD_RUN0;
      busy_q  <= 1'b0;
      inv_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      saved_q <= saved_d;
      busy_q  <= busy_d;
      inv_q   <= inv_d;
    end
  end

  p_busy_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(mode_q));

  p_low_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_low(pend_q)) |-> is_run(mode_q));

  p_irq_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !busy_q && is_run(mode_q) && irq_pend && is_low(wr_target))
      |=> (!busy_q && !$rose(inv_q)));

  p_exit_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_low(mode_q)) |=> (mode_q == $past(saved_q)));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && !clr_wr) |=> inv_q);

endmodule

// File: rtl/pmc_out_sel.sv
module pmc_out_sel
  import pmc_pkg::*;
#(
  parameter int NDOM = 8,
  parameter int NCLK = 4,
  localparam int CFG_W = 2 + NCLK + NDOM
) (
  input  mode_e                           mode,
  input  logic [CFG_SLOTS-1:0][CFG_W-1:0] cfg_q,
  output logic [NDOM-1:0]                 dom_en,
  output logic [1:0]                      flash_pwr,
  output logic [NCLK-1:0]                 clk_en,
  output logic                            core_clk_en
);

  logic [CFG_W-1:0] sel;
  logic [1:0]       fl_raw;

  always_comb begin
    if (mode == MD_HALT) sel = cfg_q[HALT_SLOT];
    else                 sel = cfg_q[mode[1:0]];
    fl_raw = sel[1:0];
  end

  always_comb begin
    core_clk_en = !is_low(mode);
    case (mode)
      MD_DRUN: begin
        dom_en    = '1;
        clk_en    = '1;
        flash_pwr = FL_NORM;
      end
      MD_STOP: begin
        dom_en    = NDOM'(2'b11);
        clk_en    = '0;
        flash_pwr = FL_OFF;
      end
      default: begin
        dom_en    = sel[2+NCLK +: NDOM] | NDOM'(2'b11);
        clk_en    = sel[2 +: NCLK];
        flash_pwr = (fl_raw == FL_LOW) ? FL_LOW :
                    (fl_raw == FL_NORM) ? FL_NORM : FL_OFF;
      end
    endcase
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NDOM = 8,
  parameter int NCLK = 4,
  localparam int CFG_W = 2 + NCLK + NDOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             irq_pend,
  input  logic             wake_evt,
  output logic [3:0]       cur_mode,
  output logic             busy,
  output logic             inv_irq,
  output logic [NDOM-1:0]  dom_en,
  output logic [1:0]       flash_pwr,
  output logic [NCLK-1:0]  clk_en,
  output logic             core_clk_en
);

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       ctl_wr, clr_wr;
  mode_e      mode;
  logic [CFG_SLOTS-1:0][CFG_W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign ctl_wr = wr_en && (wr_addr == A_CTRL);
  assign clr_wr = wr_en && (wr_addr == A_STAT) && wr_data[0];

  pmc_cfg_bank #(.NDOM(NDOM), .NCLK(NCLK)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_q   (cfg_q)
  );

  pmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_wr    (ctl_wr),
    .clr_wr    (clr_wr),
    .wr_target (wr_data[3:0]),
    .irq_pend  (irq_pend),
    .wake_evt  (wake_evt),
    .mode_q    (mode),
    .busy_q    (busy),
    .inv_q     (inv_irq)
  );

  pmc_out_sel #(.NDOM(NDOM), .NCLK(NCLK)) u_out (
    .mode        (mode),
    .cfg_q       (cfg_q),
    .dom_en      (dom_en),
    .flash_pwr   (flash_pwr),
    .clk_en      (clk_en),
    .core_clk_en (core_clk_en)
  );

  assign cur_mode = mode;

endmodule

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;

  localparam int NDOM  = 8;
  localparam int NCLK  = 4;
  localparam int CFG_W = 2 + NCLK + NDOM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CFG_W-1:0] wr_data = '0;
  logic irq_pend = 1'b0;
  logic wake_evt = 1'b0;
  logic [3:0] cur_mode;
  logic busy, inv_irq, core_clk_en;
  logic [NDOM-1:0] dom_en;
  logic [1:0] flash_pwr;
  logic [NCLK-1:0] clk_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.NDOM(NDOM), .NCLK(NCLK)) u_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_pend(irq_pend), .wake_evt(wake_evt),
    .cur_mode(cur_mode), .busy(busy), .inv_irq(inv_irq), .dom_en(dom_en),
    .flash_pwr(flash_pwr), .clk_en(clk_en), .core_clk_en(core_clk_en)
  );

  // behavioural reference model
  int m_mode, m_busy, m_pend, m_saved, m_inv;
  int m_cfg[5];
  localparam int CFG_DEF = (((1 << NDOM) - 1) << (2 + NCLK)) | (((1 << NCLK) - 1) << 2);

  function automatic bit run_m(int m); return m >= 4 && m <= 7; endfunction
  function automatic bit low_m(int m); return m == 8 || m == 10; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3; m_busy = 0; m_pend = 3; m_saved = 4; m_inv = 0;
      foreach (m_cfg[i]) m_cfg[i] = CFG_DEF;
    end else begin
      int code;
      bit bad, ok;
      code = int'(wr_data[3:0]);
      bad = 0; ok = 0;
      if (wr_en && wr_addr == 0 && m_busy == 0) begin
        if (!(code == 3 || run_m(code) || low_m(code))) bad = 1;
        else if (low_m(code)) begin
          if (!run_m(m_mode)) bad = 1;
          else if (!irq_pend) ok = 1;
        end else if (run_m(m_mode) || m_mode == 3) ok = 1;
        else bad = 1;
      end
      if (wr_en && wr_addr >= 2 && wr_addr <= 6) m_cfg[wr_addr - 2] = int'(wr_data);
      if (bad) m_inv = 1;
      else if (wr_en && wr_addr == 1 && wr_data[0]) m_inv = 0;
      if (m_busy) begin
        m_mode = m_pend; m_busy = 0;
      end else if ((m_mode == 8 && irq_pend) || (m_mode == 10 && (irq_pend || wake_evt))) begin
        m_pend = m_saved; m_busy = 1;
      end else if (ok) begin
        m_pend = code; m_busy = 1;
        if (low_m(code)) m_saved = m_mode;
      end
    end
  end

  function automatic int e_cfg();
    return (m_mode == 8) ? m_cfg[4] : m_cfg[m_mode - 4];
  endfunction
  function automatic int e_dom();
    if (m_mode == 3) return (1 << NDOM) - 1;
    if (m_mode == 10) return 3;
    return ((e_cfg() >> (2 + NCLK)) & ((1 << NDOM) - 1)) | 3;
  endfunction
  function automatic int e_clk();
    if (m_mode == 3) return (1 << NCLK) - 1;
    if (m_mode == 10) return 0;
    return (e_cfg() >> 2) & ((1 << NCLK) - 1);
  endfunction
  function automatic int e_fl();
    int f;
    if (m_mode == 3) return 0;
    if (m_mode == 10) return 2;
    f = e_cfg() & 3;
    return (f == 3) ? 2 : f;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 mode", int'(cur_mode), m_mode);
      check("R9 busy", int'(busy), m_busy);
      check("R8 inv", int'(inv_irq), m_inv);
      check("R6 dom", int'(dom_en), e_dom());
      check("R7 clk", int'(clk_en), e_clk());
      check("R7 flash", int'(flash_pwr), e_fl());
      check("R3 core", int'(core_clk_en), (low_m(m_mode) ? 0 : 1));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = CFG_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    check("R1 mode", int'(cur_mode), 3);
    check("R1 dom", int'(dom_en), 8'hFF);
    check("R1 flash", int'(flash_pwr), 0);
    check("R1 inv", int'(inv_irq), 0);
    check("R1 clk", int'(clk_en), 4'hF);

    // R3/R8: HALT from DRUN rejected
    wr(0, 8);
    check("R3 halt from drun busy", int'(busy), 0);
    check("R8 flag set", int'(inv_irq), 1);
    wr(1, 1);
    check("R8 flag cleared", int'(inv_irq), 0);

    // R2: DRUN -> RUN2
    wr(0, 6);
    check("R2 busy", int'(busy), 1);
    check("R2 old mode held", int'(cur_mode), 3);
    @(negedge clk);
    check("R2 new mode", int'(cur_mode), 6);

    // R7/R6: RUN2 config, low domain mask bits clear
    wr(4, (8'h0C << 6) | (5 << 2) | 1);
    check("R6 low domains forced", int'(dom_en), 8'h0F);
    check("R7 clk from cfg", int'(clk_en), 5);
    check("R7 flash low", int'(flash_pwr), 1);

    // R8: reserved code
    wr(0, 15);
    check("R8 reserved flag", int'(inv_irq), 1);
    check("R8 mode kept", int'(cur_mode), 6);
    wr(1, 1);

    // R9: back-to-back control writes
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = CFG_W'(5);
    @(negedge clk); wr_data = CFG_W'(7);
    @(negedge clk); wr_en = 0;
    check("R9 second write ignored", int'(cur_mode), 5);
    check("R9 no flag", int'(inv_irq), 0);
    idle(2);
    check("R9 mode stays", int'(cur_mode), 5);

    // HALT configuration with flash code 11
    wr(6, (8'h30 << 6) | 3);

    // R4: HALT while irq pending dropped
    irq_pend = 1;
    wr(0, 8);
    check("R4 no busy", int'(busy), 0);
    check("R4 no flag", int'(inv_irq), 0);
    @(negedge clk);
    check("R4 mode kept", int'(cur_mode), 5);
    irq_pend = 0;

    // R3: HALT accepted
    wr(0, 8);
    @(negedge clk);
    check("R3 in halt", int'(cur_mode), 8);
    check("R3 core clock off", int'(core_clk_en), 0);
    check("R7 flash 11 off", int'(flash_pwr), 2);
    check("R7 halt domains", int'(dom_en), 8'h33);
    idle(3);

    // R8: run code from HALT rejected
    wr(0, 4);
    check("R8 from halt", int'(inv_irq), 1);
    wr(1, 1);

    // R5: wake alone does not end HALT
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    idle(2);
    check("R5 wake ignored in halt", int'(cur_mode), 8);

    // R5: irq ends HALT, back to RUN1
    @(negedge clk); irq_pend = 1;
    @(negedge clk); irq_pend = 0;
    check("R5 exit busy", int'(busy), 1);
    @(negedge clk);
    check("R5 back to saved", int'(cur_mode), 5);

    // R10/R5: STOP, leave by wake
    wr(0, 10);
    @(negedge clk);
    check("R10 stop mode", int'(cur_mode), 10);
    check("R10 stop domains", int'(dom_en), 3);
    check("R10 stop clocks", int'(clk_en), 0);
    idle(2);
    @(negedge clk); wake_evt = 1;
    @(negedge clk); wake_evt = 0;
    @(negedge clk);
    check("R5 stop wake exit", int'(cur_mode), 5);

    // R5: STOP left by irq
    wr(0, 10);
    idle(2);
    @(negedge clk); irq_pend = 1;
    @(negedge clk); irq_pend = 0;
    @(negedge clk);
    check("R5 stop irq exit", int'(cur_mode), 5);

    // R10: DRUN request from run
    wr(0, 3);
    @(negedge clk);
    check("R10 drun mode", int'(cur_mode), 3);
    check("R10 drun domains", int'(dom_en), 8'hFF);
    check("R10 drun flash", int'(flash_pwr), 0);

    // R2: RUN0 from DRUN, default config
    wr(0, 4);
    @(negedge clk);
    check("R2 run0", int'(cur_mode), 4);
    idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule